// File: doc/BRIEF.md
# Shared-Memory Ownership Lock

This block is a small lock register that decides which of several bus masters may use a shared SRAM. Each master has its own write port into the register. All masters see the same read-back value.

To claim the memory, a master writes its identifier. It then reads the register back and treats the memory as its own only if it sees its own identifier. To give the memory back, the owner writes the idle code, which is all zeros. Every identifier is a single set bit, so if claims from several masters land in the same cycle the stored value has more than one bit set. When that happens the block raises a collision flag and returns to idle one cycle later, and every contender backs off and retries.

Writes from other masters cannot disturb an owner. A hold counter forces a release when an owner goes silent for longer than a programmable limit. A registered one-hot grant output drives the memory multiplexer.

Top module: `shmem_owner_lock`

## Requirements
- R1: After a synchronous reset, `lock_q`, `grant`, `collision`, `timeout` and `rel_err` are all zero.
- R2: Master i owns the lock from the clock edge after it writes its own identifier while the register is idle. The identifier has only bit i set. One cycle after the write, `lock_q` equals that identifier.
- R3: While one master owns the lock, a claim write from any other master is ignored and `lock_q` does not change.
- R4: A write of all zeros from the current owner returns `lock_q` to zero at the next edge.
- R5: When two or more masters write their own identifiers in the same idle cycle, the next value of `lock_q` is the OR of those identifiers and `collision` is high for exactly that one cycle. At the edge after that, `lock_q` is zero, and any writes made during the collision cycle are ignored.
- R6: With `hold_limit` = L, an owner that makes no access is removed at the (L+1)th edge after its last claim or access. At that edge `lock_q` becomes zero and `timeout` is high for one cycle. If the owner releases at the same edge, the release wins and no timeout is flagged.
- R7: An access by the owner (its `mem_acc` bit high) reloads the hold counter to L, so the owner keeps the lock past L cycles for as long as it keeps accessing.
- R8: A zero write from any master that is not the current owner is ignored. This includes a zero write while the register is idle or in the collision cycle. Such a write sets `rel_err`, which stays set until reset.
- R9: A write whose value is neither zero nor the writer's own identifier is ignored and raises no flag.
- R10: `grant` equals `lock_q` whenever `lock_q` has exactly one bit set, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N | Per-master write strobe |
| wr_data | input | N*N | Per-master write value; master i uses bits [i*N +: N] |
| mem_acc | input | N | Per-master memory access indication |
| hold_limit | input | HOLD_W | Idle cycles an owner is allowed before a forced release |
| lock_q | output | N | Register read-back value |
| grant | output | N | One-hot grant to the memory multiplexer |
| collision | output | 1 | One-cycle pulse when claims overlapped |
| timeout | output | 1 | One-cycle pulse on a forced release |
| rel_err | output | 1 | Sticky flag for a release from a non-owner |

## Verification
Directed sequences exercise each case on its own:
- a lone claim against claims made while the lock is held, which separates acceptance from blocking;
- a single claim against two claims in the same cycle, which separates ownership from collision;
- a steady stream of accesses against silence, which shows whether the counter reloads or expires;
- foreign zero writes against malformed values, which separates the sticky error from silent discard.

A random phase then mixes claims, releases, malformed writes and accesses from all masters with a short hold limit. This reaches orderings the directed cases miss, such as a claim landing in the cycle an owner times out or releases.

// File: rtl/shl_pkg.sv
package shl_pkg;
  localparam int unsigned SHL_MASTERS_DEF = 4;
  localparam int unsigned SHL_HOLD_W_DEF  = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OWNED = 2'd1,
    ST_CLASH = 2'd2
  } shl_state_e;
endpackage

// File: rtl/shl_wr_decode.sv
module shl_wr_decode #(
  parameter int unsigned N = shl_pkg::SHL_MASTERS_DEF
) (
  input  logic [N-1:0]   wr_en,
  input  logic [N*N-1:0] wr_data,
  output logic [N-1:0]   claim,
  output logic [N-1:0]   rel
);
  for (genvar g = 0; g < N; g++) begin : g_port
    localparam logic [N-1:0] MY_ID = {{(N-1){1'b0}}, 1'b1} << g;
    logic [N-1:0] val;
    assign val      = wr_data[g*N +: N];
    assign claim[g] = wr_en[g] && (val == MY_ID);
    assign rel[g]   = wr_en[g] && (val == '0);
  end
endmodule

// File: rtl/shl_hold_timer.sv
module shl_hold_timer #(
  parameter int unsigned W = shl_pkg::SHL_HOLD_W_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                      cnt_q <= '0;
    else if (load)                cnt_q <= limit;
    else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/shmem_owner_lock.sv
module shmem_owner_lock #(
  parameter int unsigned N      = shl_pkg::SHL_MASTERS_DEF,
  parameter int unsigned HOLD_W = shl_pkg::SHL_HOLD_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      wr_en,
  input  logic [N*N-1:0]    wr_data,
  input  logic [N-1:0]      mem_acc,
  input  logic [HOLD_W-1:0] hold_limit,
  output logic [N-1:0]      lock_q,
  output logic [N-1:0]      grant,
  output logic              collision,
  output logic              timeout,
  output logic              rel_err
);
  import shl_pkg::*;

  logic [N-1:0] claim, rel;
  logic [N-1:0] own_mask, lock_n, grant_n;
  logic         claim_multi, claim_single;
  logic         owner_rel, owner_acc, foreign_rel;
  logic         coll_n, to_n;
  logic         tmr_load, tmr_run, tmr_zero;
  shl_state_e   state;

  shl_wr_decode #(.N(N)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .claim   (claim),
    .rel     (rel)
  );

  // Present state follows from the number of set bits in the register.
  always_comb begin
    if (lock_q == '0)                      state = ST_IDLE;
    else if ((lock_q & (lock_q - 1'b1)) != '0) state = ST_CLASH;
    else                                   state = ST_OWNED;
  end

  assign claim_multi  = (claim & (claim - 1'b1)) != '0;
  assign claim_single = (claim != '0) && !claim_multi;
  assign own_mask     = (state == ST_OWNED) ? lock_q : '0;
  assign owner_rel    = |(rel & own_mask);
  assign owner_acc    = |(mem_acc & own_mask);
  assign foreign_rel  = |(rel & ~own_mask);

  assign tmr_load = ((state == ST_IDLE) && claim_single) || owner_acc;
  assign tmr_run  = (state == ST_OWNED) && !owner_rel;

  shl_hold_timer #(.W(HOLD_W)) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load  (tmr_load),
    .run   (tmr_run),
    .limit (hold_limit),
    .zero  (tmr_zero)
  );

  always_comb begin
    lock_n = lock_q;
    coll_n = 1'b0;
    to_n   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        lock_n = claim;
        coll_n = claim_multi;
      end
      ST_OWNED: begin
        if (owner_rel)      lock_n = '0;
        else if (owner_acc) lock_n = lock_q;
        else if (tmr_zero) begin
          lock_n = '0;
          to_n   = 1'b1;
        end
      end
      default: lock_n = '0;
    endcase
  end

  assign grant_n = ((lock_n != '0) && ((lock_n & (lock_n - 1'b1)) == '0)) ? lock_n : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q    <= '0;
      grant     <= '0;
      collision <= 1'b0;
      timeout   <= 1'b0;
      rel_err   <= 1'b0;
    end else begin
      lock_q    <= lock_n;
      grant     <= grant_n;
      collision <= coll_n;
      timeout   <= to_n;
      rel_err   <= rel_err | foreign_rel;
    end
  end
endmodule

// File: rtl/shl_lock_checker.sv
module shl_lock_checker #(
  parameter int unsigned N = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] lock_q,
  input logic [N-1:0] grant,
  input logic         collision,
  input logic         timeout,
  input logic         rel_err
);
  a_r10_grant_owner: assert property (@(posedge clk) disable iff (rst)
    $onehot(lock_q) |-> grant == lock_q);
  a_r10_grant_quiet: assert property (@(posedge clk) disable iff (rst)
    !$onehot(lock_q) |-> grant == '0);
  a_r5_clash_value: assert property (@(posedge clk) disable iff (rst)
    collision |-> $countones(lock_q) > 1);
  a_r5_clash_clears: assert property (@(posedge clk) disable iff (rst)
    collision |=> lock_q == '0);
  a_r6_timeout_idle: assert property (@(posedge clk) disable iff (rst)
    timeout |-> lock_q == '0 && $onehot($past(lock_q)));
  a_r3_no_handover: assert property (@(posedge clk) disable iff (rst)
    $onehot(lock_q) |=> (lock_q == $past(lock_q) || lock_q == '0));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
    rel_err |=> rel_err);
endmodule

bind shmem_owner_lock shl_lock_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lock_q    (lock_q),
  .grant     (grant),
  .collision (collision),
  .timeout   (timeout),
  .rel_err   (rel_err)
);

// File: tb/shmem_owner_lock_bench.sv
module shmem_owner_lock_bench;
  localparam int N = 4;
  localparam int HW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0]   wr_en   = '0;
  logic [N*N-1:0] wr_data = '0;
  logic [N-1:0]   mem_acc = '0;
  logic [HW-1:0]  hold_limit = 8'd3;
  logic [N-1:0]   lock_q, grant;
  logic           collision, timeout, rel_err;

  int n_chk = 0;
  int n_fail = 0;

  logic [N-1:0]  m_lock, m_grant;
  logic          m_coll, m_to, m_err;
  logic [HW-1:0] m_cnt;

  always #4 clk = ~clk;

  shmem_owner_lock #(.N(N), .HOLD_W(HW)) u_shmem_owner_lock (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .mem_acc(mem_acc),
    .hold_limit(hold_limit), .lock_q(lock_q), .grant(grant),
    .collision(collision), .timeout(timeout), .rel_err(rel_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int m, input logic [N-1:0] v);
    wr_en[m] = 1'b1;
    wr_data[m*N +: N] = v;
  endtask

  task automatic idle_in();
    wr_en = '0;
    wr_data = '0;
    mem_acc = '0;
  endtask

  function automatic logic [N-1:0] id_of(input int m);
    return N'(1) << m;
  endfunction

  function automatic bit single(input logic [N-1:0] v);
    return $countones(v) == 1;
  endfunction

  // Reference model built from R2..R10, advanced once per clock edge.
  task automatic model_step();
    logic [N-1:0] cl, rl, own, nxt;
    logic oacc, orel, nto, ncol;
    cl = '0;
    rl = '0;
    for (int i = 0; i < N; i++) begin
      if (wr_en[i] && wr_data[i*N +: N] == id_of(i)) cl[i] = 1'b1;
      if (wr_en[i] && wr_data[i*N +: N] == '0) rl[i] = 1'b1;
    end
    own  = single(m_lock) ? m_lock : '0;
    oacc = |(mem_acc & own);
    orel = |(rl & own);
    nto  = 1'b0;
    ncol = 1'b0;
    nxt  = '0;
    if (m_lock == '0) begin
      nxt  = cl;
      ncol = $countones(cl) > 1;
      if (single(cl)) m_cnt = hold_limit;
    end else if (single(m_lock)) begin
      if (orel) nxt = '0;
      else if (oacc) begin
        nxt = m_lock;
        m_cnt = hold_limit;
      end else if (m_cnt == '0) begin
        nxt = '0;
        nto = 1'b1;
      end else begin
        nxt = m_lock;
        m_cnt = m_cnt - 1'b1;
      end
    end
    m_err   = m_err | (|(rl & ~own));
    m_lock  = nxt;
    m_grant = single(nxt) ? nxt : '0;
    m_coll  = ncol;
    m_to    = nto;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    chk("R1 lock", lock_q, 0);
    chk("R1 grant", grant, 0);
    chk("R1 flags", {collision, timeout, rel_err}, 0);

    // R2 single claim by master 1
    wr(1, 4'b0010);
    cyc();
    idle_in();
    chk("R2 lock", lock_q, 4'b0010);
    chk("R10 grant owned", grant, 4'b0010);

    // R3 claim by another master while owned
    wr(2, 4'b0100);
    cyc();
    idle_in();
    chk("R3 lock kept", lock_q, 4'b0010);

    // R8 foreign release
    wr(0, 4'b0000);
    cyc();
    idle_in();
    chk("R8 lock kept", lock_q, 4'b0010);
    chk("R8 err set", rel_err, 1);

    // R7 accesses keep the lock beyond the limit
    mem_acc = 4'b0010;
    repeat (5) cyc();
    chk("R7 held by access", lock_q, 4'b0010);
    mem_acc = '0;

    // R6 timeout at the (L+1)th silent edge
    repeat (3) cyc();
    chk("R6 still owned", lock_q, 4'b0010);
    chk("R6 no early timeout", timeout, 0);
    cyc();
    chk("R6 forced idle", lock_q, 0);
    chk("R6 timeout pulse", timeout, 1);
    cyc();
    chk("R6 pulse ends", timeout, 0);

    // R9 malformed write ignored
    wr(3, 4'b1100);
    cyc();
    idle_in();
    chk("R9 lock idle", lock_q, 0);
    chk("R9 no flags", {collision, timeout}, 0);

    // R4 owner release
    wr(2, 4'b0100);
    cyc();
    idle_in();
    chk("R2 lock m2", lock_q, 4'b0100);
    wr(2, 4'b0000);
    cyc();
    idle_in();
    chk("R4 released", lock_q, 0);
    chk("R4 grant cleared", grant, 0);

    // R5 simultaneous claims
    wr(0, 4'b0001);
    wr(3, 4'b1000);
    cyc();
    idle_in();
    chk("R5 OR value", lock_q, 4'b1001);
    chk("R5 collision", collision, 1);
    chk("R10 grant zero on clash", grant, 0);
    wr(1, 4'b0010);
    cyc();
    idle_in();
    chk("R5 back to idle", lock_q, 0);
    chk("R5 pulse ends", collision, 0);
    chk("R8 err sticky", rel_err, 1);

    // R6 release at the expiry edge: release wins
    hold_limit = 8'd0;
    wr(3, 4'b1000);
    cyc();
    wr(3, 4'b0000);
    cyc();
    idle_in();
    chk("R6 release wins", {lock_q, timeout}, 0);

    // Random phase against the model
    rst = 1'b1;
    cyc();
    rst = 1'b0;
    chk("R1 err cleared", rel_err, 0);
    hold_limit = 8'd4;
    m_lock = '0; m_grant = '0; m_coll = 0; m_to = 0; m_err = 0; m_cnt = '0;
    void'($urandom(32'd1234));
    for (int k = 0; k < 400; k++) begin
      idle_in();
      for (int i = 0; i < N; i++) begin
        int r;
        r = int'($urandom_range(99));
        if (r < 12) wr(i, id_of(i));
        else if (r < 18) wr(i, '0);
        else if (r < 20) wr(i, N'($urandom));
        mem_acc[i] = ($urandom_range(99) < 25);
      end
      model_step();
      cyc();
      chk("R2/R3/R4/R6/R7 random lock", lock_q, m_lock);
      chk("R10 random grant", grant, m_grant);
      chk("R5/R6/R8 random flags", {collision, timeout, rel_err}, {m_coll, m_to, m_err});
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule